// File: doc/BRIEF.md
# Multi-Layer Scrolling Line Compositor

This block produces the pixel stream for a raster display from up to four stacked picture layers held in external memory. Each layer owns one line store. When the video timing generator asks for the next line, the block runs one burst read per visible layer through the memory arbiter and fills that layer's store. While the line is shown, the stores are read at the column the timing generator presents. Their pixels are merged bottom-up into a single 12-bit RGB value.

Every layer has its own memory base, picture width (stride), height and a horizontal and vertical scroll offset. Scrolling therefore costs nothing but a different start address for the next burst. A layer may be much larger than the visible window. Each layer is merged either with binary transparency or with alpha weighting. Configuration is written through a small register port into pending copies, and these take effect together when the frame-start pulse arrives.

Top module: `layer_compositor`

## Requirements
- R1: After reset, outRgb is 0 (black) and memReq is low, and no layer contributes until one has been fetched.
- R2: Pixels are 16 bits, red [15:12], green [11:8], blue [7:4], alpha [3:0]. In binary mode, a pixel with alpha 0 leaves the colour below unchanged, and any other alpha replaces it with the pixel's RGB.
- R3: In alpha mode each channel becomes (top·w + below·(16−w)) >> 4, where w is the alpha value, except that alpha 15 gives w = 16.
- R4: Layer 0 is the bottom and layer 3 the top. Merging starts from black and applies layers 0, 1, 2, 3 in turn.
- R5: A fetch request starts one burst per enabled, visible layer, in ascending layer order. Each burst has memLen = LINE_PIX and the start address base + scrollX + (row + scrollY)·stride, and memReq with memAddr stays stable until memGnt.
- R6: The scroll offsets change only the burst start address, so the displayed line shifts by the offset.
- R7: A disabled layer is not fetched and contributes nothing. With no layer contributing, the output is black.
- R8: A layer with row + scrollY ≥ height is not fetched for that line and is transparent on it.
- R9: Register writes (cfgAddr = {layer[1:0], field[2:0]}: 0 base, 1 stride, 2 height, 3 scrollX, 4 scrollY, 5 control with bit0 enable and bit1 alpha mode) have no effect until a frameStart pulse.
- R10: outRgb shows the merged pixel of the column presented on pixCol two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Layer index [4:3] and field [2:0] |
| cfgData | input | 32 | Configuration write data |
| frameStart | input | 1 | Moves pending configuration into the active copy |
| fetchReq | input | 1 | Pulse: fetch the line given on fetchRow |
| fetchRow | input | 16 | Screen row for the line fetch |
| pixCol | input | COL_W | Column counter from the timing generator |
| memReq | output | 1 | Burst read request |
| memAddr | output | ADDR_W | Burst start address |
| memLen | output | 16 | Burst length in pixels |
| memGnt | input | 1 | Arbiter accepts the request |
| memValid | input | 1 | Read data beat valid |
| memData | input | 16 | Read data beat |
| outRgb | output | 12 | Merged pixel, R[11:8] G[7:4] B[3:0] |

## Verification
A wrong fetch counter or address term shows up on the memory port within the same line: a burst to the wrong start address, a missing or extra burst, or bursts out of layer order, all visible before any pixel is shown. A corrupted line store, a validity flag or a blend term shows up as a wrong outRgb value two edges after the affected column. Shadow-register faults show up as an address change on the first fetch after a write but before frameStart. Each scenario changes one input pattern (scroll, enable, height, mode), so a fault points to a single piece of state.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;
  // Layer index width; NUM_LAYERS must not exceed 1 << LYR_W.
  localparam int LYR_W = 2;
  localparam int IDX_W = 16;

  typedef enum logic [1:0] {F_IDLE, F_CHECK, F_REQ, F_RECV} fetchStateT;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] stride;
    logic [15:0] height;
    logic [15:0] scrollX;
    logic [15:0] scrollY;
    logic        enable;
    logic        alphaMode;
  } layerCfgT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             wrEn;
    logic [LYR_W-1:0] layer;
    logic [IDX_W-1:0] idx;
    logic             validSet;
    logic             validClr;
  } fillStrobeT;
endpackage

// File: rtl/lcomp_fetch_ctrl.sv
module lcomp_fetch_ctrl
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int LINE_PIX   = 320,
  parameter int ADDR_W     = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [LYR_W+2:0]      cfgAddr,
  input  logic [31:0]           cfgData,
  input  logic                  frameStart,
  input  logic                  fetchReq,
  input  logic [15:0]           fetchRow,
  input  logic                  memGnt,
  input  logic                  memValid,
  output logic                  memReq,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [15:0]           memLen,
  output fillStrobeT            strobe,
  output logic [NUM_LAYERS-1:0] shEnable,
  output logic [NUM_LAYERS-1:0] shAlpha
);
  localparam int LIDX_W = LYR_W + 1;

  layerCfgT   pendCfg [NUM_LAYERS];
  layerCfgT   actCfg  [NUM_LAYERS];
  fetchStateT state;
  logic [LIDX_W-1:0] layerIdx;
  logic [15:0]       rowQ;
  logic [IDX_W-1:0]  beat;

  // Register port into pending copies, copied on frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
        pendCfg[l] <= '0;
        actCfg[l]  <= '0;
      end
    end else begin
      if (frameStart)
        for (int l = 0; l < NUM_LAYERS; l++) actCfg[l] <= pendCfg[l];
      if (cfgWe && 32'(cfgAddr[LYR_W+2:3]) < NUM_LAYERS) begin
        case (cfgAddr[2:0])
          3'd0: pendCfg[cfgAddr[LYR_W+2:3]].base    <= cfgData;
          3'd1: pendCfg[cfgAddr[LYR_W+2:3]].stride  <= cfgData[15:0];
          3'd2: pendCfg[cfgAddr[LYR_W+2:3]].height  <= cfgData[15:0];
          3'd3: pendCfg[cfgAddr[LYR_W+2:3]].scrollX <= cfgData[15:0];
          3'd4: pendCfg[cfgAddr[LYR_W+2:3]].scrollY <= cfgData[15:0];
          3'd5: begin
            pendCfg[cfgAddr[LYR_W+2:3]].enable    <= cfgData[0];
            pendCfg[cfgAddr[LYR_W+2:3]].alphaMode <= cfgData[1];
          end
          default: ;
        endcase
      end
    end
  end

  // Visibility and start address of the layer under inspection
  layerCfgT          curCfg;
  logic [16:0]       lineNo;
  logic [31:0]       lineOfs;
  logic              curVis;
  logic [ADDR_W-1:0] startAddr;
  logic              allDone;

  always_comb begin
    curCfg    = actCfg[layerIdx[LYR_W-1:0]];
    lineNo    = {1'b0, rowQ} + {1'b0, curCfg.scrollY};
    lineOfs   = 32'(lineNo) * 32'(curCfg.stride);
    curVis    = curCfg.enable && (lineNo < {1'b0, curCfg.height});
    startAddr = ADDR_W'(curCfg.base + 32'(curCfg.scrollX) + lineOfs);
    allDone   = 32'(layerIdx) >= NUM_LAYERS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= F_IDLE;
      layerIdx <= '0;
      rowQ     <= '0;
      beat     <= '0;
      memAddr  <= '0;
    end else begin
      case (state)
        F_IDLE: if (fetchReq) begin
          rowQ     <= fetchRow;
          layerIdx <= '0;
          state    <= F_CHECK;
        end
        F_CHECK: begin
          if (allDone) state <= F_IDLE;
          else if (curVis) begin
            memAddr <= startAddr;
            state   <= F_REQ;
          end else layerIdx <= layerIdx + 1'b1;
        end
        F_REQ: if (memGnt) begin
          beat  <= '0;
          state <= F_RECV;
        end
        F_RECV: if (memValid) begin
          if (32'(beat) == LINE_PIX - 1) begin
            layerIdx <= layerIdx + 1'b1;
            state    <= F_CHECK;
          end else beat <= beat + 1'b1;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    memReq          = (state == F_REQ);
    memLen          = 16'(LINE_PIX);
    strobe.wrEn     = (state == F_RECV) && memValid;
    strobe.layer    = layerIdx[LYR_W-1:0];
    strobe.idx      = beat;
    strobe.validSet = strobe.wrEn && (32'(beat) == LINE_PIX - 1);
    strobe.validClr = (state == F_CHECK) && !allDone && !curVis;
  end

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : gShadow
    assign shEnable[g] = actCfg[g].enable;
    assign shAlpha[g]  = actCfg[g].alphaMode;
  end

  // R5: request and its address held until accepted
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr));
  // R5: the arbiter grants only a pending request
  p_gnt_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    memGnt |-> memReq);
  // R5: no store write beyond the line length
  p_beat_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> 32'(strobe.idx) < LINE_PIX);
endmodule

// File: rtl/lcomp_line_blend.sv
module lcomp_line_blend
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int LINE_PIX   = 320,
  parameter int COL_W      = $clog2(LINE_PIX)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fillStrobeT            strobe,
  input  logic [15:0]           memData,
  input  logic [COL_W-1:0]      pixCol,
  input  logic [NUM_LAYERS-1:0] shEnable,
  input  logic [NUM_LAYERS-1:0] shAlpha,
  output logic [11:0]           outRgb
);
  logic [NUM_LAYERS-1:0][15:0] rdPix;
  logic [NUM_LAYERS-1:0]       lineValid;
  logic [NUM_LAYERS-1:0]       layerOn;

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : gStore
    logic [15:0] lineMem [LINE_PIX];
    logic [15:0] rdQ;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.layer == LYR_W'(g) && 32'(strobe.idx) < LINE_PIX)
        lineMem[strobe.idx[COL_W-1:0]] <= memData;
      rdQ <= (32'(pixCol) < LINE_PIX) ? lineMem[pixCol] : 16'h0;
    end
    assign rdPix[g] = rdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lineValid <= '0;
    else
      for (int l = 0; l < NUM_LAYERS; l++)
        if (strobe.layer == LYR_W'(l)) begin
          if (strobe.validSet) lineValid[l] <= 1'b1;
          if (strobe.validClr) lineValid[l] <= 1'b0;
        end
  end

  assign layerOn = lineValid & shEnable;

  function automatic logic [3:0] mixCh(input logic [3:0] top, input logic [3:0] below,
                                       input logic [4:0] w);
    logic [8:0] sum;
    sum = 9'(top) * 9'(w) + 9'(below) * 9'(5'd16 - w);
    return sum[7:4];
  endfunction

  logic [11:0] mixed;
  always_comb begin
    logic [4:0] w;
    mixed = 12'h0;
    for (int l = 0; l < NUM_LAYERS; l++) begin
      w = (rdPix[l][3:0] == 4'hF) ? 5'd16 : {1'b0, rdPix[l][3:0]};
      if (layerOn[l]) begin
        if (!shAlpha[l]) begin
          if (rdPix[l][3:0] != 4'h0) mixed = rdPix[l][15:4];
        end else begin
          mixed = {mixCh(rdPix[l][15:12], mixed[11:8], w),
                   mixCh(rdPix[l][11:8],  mixed[7:4],  w),
                   mixCh(rdPix[l][7:4],   mixed[3:0],  w)};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outRgb <= 12'h0;
    else       outRgb <= mixed;
  end

  // R7: nothing contributing gives black on the next edge
  p_empty_black_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(|layerOn) |=> outRgb == 12'h0);
  // R5: a line is marked present only on its final beat
  p_valid_on_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.validSet |-> strobe.wrEn);
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int LINE_PIX   = 320,
  parameter int ADDR_W     = 23,
  localparam int COL_W     = $clog2(LINE_PIX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [4:0]        cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              frameStart,
  input  logic              fetchReq,
  input  logic [15:0]       fetchRow,
  input  logic [COL_W-1:0]  pixCol,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memLen,
  input  logic              memGnt,
  input  logic              memValid,
  input  logic [15:0]       memData,
  output logic [11:0]       outRgb
);
  fillStrobeT            strobe;
  logic [NUM_LAYERS-1:0] shEnable;
  logic [NUM_LAYERS-1:0] shAlpha;

  lcomp_fetch_ctrl #(.NUM_LAYERS(NUM_LAYERS), .LINE_PIX(LINE_PIX), .ADDR_W(ADDR_W)) uCtrl (
    .clk, .rstN, .cfgWe, .cfgAddr, .cfgData, .frameStart, .fetchReq, .fetchRow,
    .memGnt, .memValid, .memReq, .memAddr, .memLen, .strobe, .shEnable, .shAlpha);

  lcomp_line_blend #(.NUM_LAYERS(NUM_LAYERS), .LINE_PIX(LINE_PIX), .COL_W(COL_W)) uBlend (
    .clk, .rstN, .strobe, .memData, .pixCol, .shEnable, .shAlpha, .outRgb);
endmodule

// File: tb/layer_compositor_test.sv
`timescale 1ns/1ps
module layer_compositor_test;
  localparam int LP = 8;
  localparam int CW = $clog2(LP);

  logic clk = 0, rstN = 0;
  logic cfgWe = 0, frameStart = 0, fetchReq = 0;
  logic [4:0] cfgAddr = 0;
  logic [31:0] cfgData = 0;
  logic [15:0] fetchRow = 0;
  logic [CW-1:0] pixCol = 0;
  logic memReq, memGnt = 0, memValid = 0;
  logic [22:0] memAddr;
  logic [15:0] memLen, memData = 0;
  logic [11:0] outRgb;

  layer_compositor #(.LINE_PIX(LP)) uut (.*);

  always #2.5 clk = ~clk;

  int nRun = 0, nFail = 0;
  logic [15:0] mem [4096];
  int reqLog [64];
  int reqCount = 0;

  int pBase[4], pStride[4], pH[4], pSx[4], pSy[4];
  bit pEn[4], pAl[4];
  int aBase[4], aStride[4], aH[4], aSx[4], aSy[4];
  bit aEn[4], aAl[4];
  bit lineOk[4];
  int lineAddr[4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory arbiter and memory model
  initial begin
    forever begin
      @(negedge clk);
      if (memReq) begin
        int base;
        base = int'(memAddr);
        if (reqCount < 64) reqLog[reqCount] = base;
        reqCount++;
        @(negedge clk); memGnt = 1;
        @(negedge clk); memGnt = 0;
        for (int i = 0; i < LP; i++) begin
          if (i == 3) begin memValid = 0; @(negedge clk); end
          memValid = 1; memData = mem[(base + i) & 12'hFFF];
          @(negedge clk);
        end
        memValid = 0;
      end
    end
  end

  task automatic wcfg(input int layer, input int field, input int data);
    @(negedge clk);
    cfgWe = 1; cfgAddr = 5'({layer[1:0], field[2:0]}); cfgData = data;
    case (field)
      0: pBase[layer] = data;  1: pStride[layer] = data;  2: pH[layer] = data;
      3: pSx[layer] = data;    4: pSy[layer] = data;
      5: begin pEn[layer] = data[0]; pAl[layer] = data[1]; end
      default: ;
    endcase
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic setLayer(input int l, input int base, input int stride, input int h,
                          input int sx, input int sy, input int en, input int al);
    wcfg(l, 0, base); wcfg(l, 1, stride); wcfg(l, 2, h);
    wcfg(l, 3, sx); wcfg(l, 4, sy); wcfg(l, 5, en | (al << 1));
  endtask

  task automatic frame();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    for (int l = 0; l < 4; l++) begin
      aBase[l] = pBase[l]; aStride[l] = pStride[l]; aH[l] = pH[l];
      aSx[l] = pSx[l]; aSy[l] = pSy[l]; aEn[l] = pEn[l]; aAl[l] = pAl[l];
    end
  endtask

  task automatic fetchLine(input int row, input string tag);
    int n0, k;
    n0 = reqCount;
    @(negedge clk); fetchRow = 16'(row); fetchReq = 1;
    @(negedge clk); fetchReq = 0;
    repeat (150) @(negedge clk);
    k = 0;
    for (int l = 0; l < 4; l++) begin
      lineOk[l] = aEn[l] && (row + aSy[l] < aH[l]);
      lineAddr[l] = aBase[l] + aSx[l] + (row + aSy[l]) * aStride[l];
      if (lineOk[l]) begin
        if (n0 + k < reqCount)
          chk(reqLog[n0 + k] == lineAddr[l], {tag, " burst address"}, reqLog[n0 + k], lineAddr[l]);
        k++;
      end
    end
    chk(reqCount - n0 == k, {tag, " burst count"}, reqCount - n0, k);
  endtask

  function automatic logic [3:0] mixCh(input logic [3:0] t, input logic [3:0] b, input int w);
    return 4'((int'(t) * w + int'(b) * (16 - w)) / 16);
  endfunction

  function automatic logic [11:0] expPix(input int c);
    logic [11:0] acc;
    logic [15:0] p;
    int w;
    acc = 0;
    for (int l = 0; l < 4; l++) if (lineOk[l]) begin
      p = mem[(lineAddr[l] + c) & 12'hFFF];
      w = (p[3:0] == 15) ? 16 : int'(p[3:0]);
      if (!aAl[l]) begin
        if (p[3:0] != 0) acc = p[15:4];
      end else
        acc = {mixCh(p[15:12], acc[11:8], w), mixCh(p[11:8], acc[7:4], w), mixCh(p[7:4], acc[3:0], w)};
    end
    return acc;
  endfunction

  task automatic checkCols(input string tag);
    for (int c = 0; c < LP; c++) begin
      @(negedge clk); pixCol = CW'(c);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(outRgb == expPix(c), tag, outRgb, expPix(c));
    end
  endtask

  task automatic disableAll();
    for (int l = 0; l < 4; l++) wcfg(l, 5, 0);
  endtask

  task automatic test_reset();
    chk(outRgb == 0, "R1 reset output", outRgb, 0);
    chk(memReq == 0, "R1 reset request", memReq, 0);
    fetchLine(0, "R7 nothing enabled");
    checkCols("R1 black before any fetch");
  endtask

  task automatic test_single();
    mem[16'h112] = 16'h5A60;  // alpha 0 pixel inside the line
    setLayer(0, 16'h100, 16, 4, 0, 0, 1, 0);
    frame();
    fetchLine(1, "R5 single layer");
    checkCols("R2 binary single layer");
    chk(memLen == LP, "R5 burst length", memLen, LP);
  endtask

  task automatic test_scroll();
    setLayer(0, 16'h100, 16, 4, 3, 1, 1, 0);
    frame();
    fetchLine(1, "R6 scrolled address");
    checkCols("R6 scrolled pixels");
  endtask

  task automatic test_alpha();
    for (int i = 0; i < LP; i++) begin
      mem[16'h200 + i] = 16'hF00F; mem[16'h300 + i] = 16'h00F8;
    end
    disableAll();
    setLayer(0, 16'h200, LP, 1, 0, 0, 1, 0);
    setLayer(1, 16'h300, LP, 1, 0, 0, 1, 1);
    frame();
    fetchLine(0, "R3 alpha setup");
    @(negedge clk); pixCol = 2;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(outRgb == 12'h707, "R3 half alpha mix", outRgb, 12'h707);
    wcfg(1, 5, 1); frame();
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(outRgb == 12'h00F, "R4 upper layer wins in binary", outRgb, 12'h00F);
    wcfg(1, 5, 0); frame();
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(outRgb == 12'hF00, "R7 disabled upper layer", outRgb, 12'hF00);
  endtask

  task automatic test_four();
    setLayer(0, 16'h040, 32, 8, 1, 0, 1, 0);
    setLayer(1, 16'h400, 20, 8, 2, 1, 1, 1);
    setLayer(2, 16'h600, 12, 8, 0, 2, 1, 0);
    setLayer(3, 16'h800, 40, 8, 5, 0, 1, 1);
    frame();
    fetchLine(2, "R5 four layers in order");
    checkCols("R4 four-layer merge");
  endtask

  task automatic test_disable();
    wcfg(2, 5, 0); frame();
    fetchLine(3, "R7 disabled not fetched");
    checkCols("R7 disabled contributes nothing");
  endtask

  task automatic test_clip();
    wcfg(1, 2, 3); frame();
    fetchLine(2, "R8 clipped layer skipped");
    checkCols("R8 clipped layer transparent");
  endtask

  task automatic test_shadow();
    int keepSx;
    keepSx = aSx[0];
    wcfg(0, 3, 9);
    fetchLine(1, "R9 pending write ignored");
    chk(aSx[0] == keepSx, "R9 model unchanged", aSx[0], keepSx);
    checkCols("R9 pixels unchanged before frame");
    frame();
    fetchLine(1, "R9 applied after frame");
    checkCols("R9 pixels after frame");
  endtask

  task automatic test_latency();
    int b;
    b = 1;
    for (int c = LP - 1; c > 0; c--) if (expPix(c) != expPix(0)) b = c;
    @(negedge clk); pixCol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); pixCol = CW'(b);
    @(posedge clk); @(negedge clk);
    chk(outRgb == expPix(0), "R10 one edge still old column", outRgb, expPix(0));
    @(posedge clk); @(negedge clk);
    chk(outRgb == expPix(b), "R10 two edges new column", outRgb, expPix(b));
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'((i * 40503 + 12345) ^ (i >> 3));
    for (int l = 0; l < 4; l++) begin
      pBase[l] = 0; pStride[l] = 0; pH[l] = 0; pSx[l] = 0; pSy[l] = 0; pEn[l] = 0; pAl[l] = 0;
      aBase[l] = 0; aStride[l] = 0; aH[l] = 0; aSx[l] = 0; aSy[l] = 0; aEn[l] = 0; aAl[l] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_single();
    test_scroll();
    test_alpha();
    test_four();
    test_disable();
    test_clip();
    test_shadow();
    test_latency();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule